// File: doc/BRIEF.md
# Serial Command Receiver and Display-Memory Writer

This block takes 16-bit command words from a three-wire serial link (active-low select, shift clock, data) and turns them into settings for an on-screen text overlay. A static order pin chooses whether each word arrives most-significant bit first or least-significant bit first. The top four bits of a word pick a command group. Some groups carry a subcommand in the next bits. The decoded commands update a small register file of display enables, output polarities, screen position and screen-background colour.

Character and line entries for the text memory are built in two steps. One command holds half of the entry in a staging register. A second command supplies the other half and starts a 24-bit write through a write port to an external memory. Character writes advance the column address after each write. Line writes leave the address unchanged. An optional fill flag makes a single character commit cover every location from the current address to the last one, one location per clock, with `busy` high for the whole run. No write happens while the horizontal sync pulse is active.

Serial inputs are sampled in the `clk` domain, so the shift clock must be slow compared with `clk`. The memory array, raster timing and pixel generation are outside this block.

Top module: `osd_cmd_rx`

## Requirements
- R1: While reset is asserted and right after it, all five enable and polarity outputs are 0, `busy` and `mem_we` are 0, the write address is row 0, column 0, and `hpos`, `vpos` and `scrbg_color` are 0.
- R2: A bit is taken on each rising edge of `ser_clk` while `ser_cs_n` is low, and 16 bits form one word. With `msb_first`=1 the first bit becomes bit 15. With `msb_first`=0 the first bit becomes bit 0.
- R3: When `ser_cs_n` goes high before the 16th bit, the partial word has no effect and the next word starts again from its first bit.
- R4: The register commands are decoded from bits 15:12, then the subcommand bits. 0x5 with 11:8=0000 sets `en_sprite`=bit 7, `en_scrbg`=bit 6 and `en_disp`=bit 4. 0x5 with 11:9=110 sets `vpos`=bits 8:0. 0x5 with 11:9=111 sets `hpos`=bits 8:0. 0x7 with 11:4=0xC0 sets `scrbg_color`=bits 3:0. 0xD with 11:10=00 sets `inv_blank`=bit 1 and `inv_color`=bit 0.
- R5: Group 0x0 sets the row to bits 11:8, the fill flag to bit 7 and the column to bits 4:0.
- R6: Group 0x1 stores bits 11:0 in the character staging register and writes nothing. Group 0x2 writes the record {staging, bits 11:0} at the current row and column with `mem_line`=0. `mem_we` is first high in the cycle after the word completes, and the column then advances by one.
- R7: A character write at column 27 leaves the column at 0 and advances the row. A character write at row 11, column 27 leaves row 0, column 0.
- R8: Group 0x3 stores bits 11:0 in the line staging register. Group 0x4 writes {line staging, bits 11:0} with `mem_line`=1 at the current row and leaves the row and column unchanged.
- R9: While `hsync_act` is high, `mem_we` stays low. A pending write waits with `busy` high and is issued in the first cycle with `hsync_act` low.
- R10: With the fill flag set, group 0x2 writes the same record at every location from the current address up to row 11, column 27, one location per cycle without sync, with `busy` high, and then leaves the address at row 0, column 0.
- R11: A word that completes while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial shift clock, bit taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| msb_first | input | 1 | Shift order: 1 = MSB first, 0 = LSB first |
| hsync_act | input | 1 | High while the horizontal sync pulse is active |
| mem_we | output | 1 | Write strobe to display memory |
| mem_line | output | 1 | 1 = line-record write, 0 = character write |
| mem_row | output | ROW_W (4) | Write row address |
| mem_col | output | COL_W (5) | Write column address |
| mem_data | output | 24 | Record to be written |
| busy | output | 1 | A write or a fill run is pending |
| en_sprite | output | 1 | Sprite display enable |
| en_scrbg | output | 1 | Screen-background enable |
| en_disp | output | 1 | Text display enable |
| inv_color | output | 1 | Invert colour-code outputs |
| inv_blank | output | 1 | Invert display-period outputs |
| vpos | output | 9 | Vertical text position |
| hpos | output | 9 | Horizontal text position |
| scrbg_color | output | 4 | Screen-background colour |

## Verification
The bench sends words in both shift orders and cuts one word short. A design that mirrored the bits or kept a stale bit count would then load a wrong `hpos` or `vpos`. It sends character writes at column 27 and at row 11, column 27. A wrong wrap would land the next record at the wrong cell or write beyond row 11. A line write is followed by a character write, and that record must land at the same column, which catches a line commit that moves the address. Holding `hsync_act` high over a commit checks that the write waits rather than being lost. A long fill run has a register word arriving in the middle of it. The bench checks the number of writes, the last cell and that the mid-fill word had no effect.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;
    localparam int CMD_W   = 16;
    localparam int PAY_W   = 12;
    localparam int REC_W   = 2 * PAY_W;
    localparam int POS_W   = 9;
    localparam int COLOR_W = 4;

    localparam logic [3:0] GRP_ADDR     = 4'h0;
    localparam logic [3:0] GRP_CHR_STG  = 4'h1;
    localparam logic [3:0] GRP_CHR_PUT  = 4'h2;
    localparam logic [3:0] GRP_LINE_STG = 4'h3;
    localparam logic [3:0] GRP_LINE_PUT = 4'h4;
    localparam logic [3:0] GRP_SCREEN   = 4'h5;
    localparam logic [3:0] GRP_BACKGND  = 4'h7;
    localparam logic [3:0] GRP_PINCTL   = 4'hD;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_CHR  = 2'd1,
        WR_LINE = 2'd2
    } wr_mode_e;
endpackage

// File: rtl/osd_ser_shift.sv
module osd_ser_shift
    import osd_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdat,
    input  logic             msb_first,
    output logic             word_vld,
    output logic [CMD_W-1:0] word
);
    localparam int CNT_W = $clog2(CMD_W + 1);

    typedef struct packed {
        logic             sclk;
        logic [CNT_W-1:0] cnt;
        logic [CMD_W-1:0] sh;
        logic             vld;
        logic [CMD_W-1:0] word;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic [CMD_W-1:0] sh_next;

    always_comb begin
        st_d      = st_q;
        st_d.sclk = sclk;
        st_d.vld  = 1'b0;
        sh_next   = msb_first ? {st_q.sh[CMD_W-2:0], sdat}
                              : {sdat, st_q.sh[CMD_W-1:1]};
        if (cs_n) begin
            st_d.cnt = '0;
        end else if (sclk && !st_q.sclk) begin
            st_d.sh = sh_next;
            if (st_q.cnt == CNT_W'(CMD_W - 1)) begin
                st_d.cnt  = '0;
                st_d.vld  = 1'b1;
                st_d.word = sh_next;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_vld = st_q.vld;
    assign word     = st_q.word;
endmodule

// File: rtl/osd_cmd_decode.sv
module osd_cmd_decode
    import osd_cmd_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               word_vld,
    input  logic [CMD_W-1:0]   word,
    input  logic               busy,
    output logic               set_addr,
    output logic [ROW_W-1:0]   addr_row,
    output logic [COL_W-1:0]   addr_col,
    output logic               addr_fill,
    output logic               chr_go,
    output logic               line_go,
    output logic [REC_W-1:0]   rec,
    output logic               en_sprite,
    output logic               en_scrbg,
    output logic               en_disp,
    output logic               inv_color,
    output logic               inv_blank,
    output logic [POS_W-1:0]   vpos,
    output logic [POS_W-1:0]   hpos,
    output logic [COLOR_W-1:0] scrbg_color
);
    typedef struct packed {
        logic [PAY_W-1:0]   stg_chr;
        logic [PAY_W-1:0]   stg_line;
        logic               en_sprite;
        logic               en_scrbg;
        logic               en_disp;
        logic               inv_color;
        logic               inv_blank;
        logic [POS_W-1:0]   vpos;
        logic [POS_W-1:0]   hpos;
        logic [COLOR_W-1:0] bgc;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic [3:0]       grp;
    logic [PAY_W-1:0] pay;
    logic             take;

    assign grp  = word[CMD_W-1 -: 4];
    assign pay  = word[PAY_W-1:0];
    assign take = word_vld && !busy;

    always_comb begin
        st_d      = st_q;
        set_addr  = 1'b0;
        chr_go    = 1'b0;
        line_go   = 1'b0;
        rec       = {st_q.stg_chr, pay};
        addr_row  = word[8 +: ROW_W];
        addr_col  = word[COL_W-1:0];
        addr_fill = word[7];
        if (take) begin
            case (grp)
                GRP_ADDR:     set_addr = 1'b1;
                GRP_CHR_STG:  st_d.stg_chr = pay;
                GRP_CHR_PUT:  chr_go = 1'b1;
                GRP_LINE_STG: st_d.stg_line = pay;
                GRP_LINE_PUT: begin
                    line_go = 1'b1;
                    rec     = {st_q.stg_line, pay};
                end
                GRP_SCREEN: begin
                    if (word[11:8] == 4'b0000) begin
                        st_d.en_sprite = word[7];
                        st_d.en_scrbg  = word[6];
                        st_d.en_disp   = word[4];
                    end else if (word[11:9] == 3'b110) begin
                        st_d.vpos = word[POS_W-1:0];
                    end else if (word[11:9] == 3'b111) begin
                        st_d.hpos = word[POS_W-1:0];
                    end
                end
                GRP_BACKGND: begin
                    if (word[11:4] == 8'hC0) st_d.bgc = word[COLOR_W-1:0];
                end
                GRP_PINCTL: begin
                    if (word[11:10] == 2'b00) begin
                        st_d.inv_blank = word[1];
                        st_d.inv_color = word[0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_sprite   = st_q.en_sprite;
    assign en_scrbg    = st_q.en_scrbg;
    assign en_disp     = st_q.en_disp;
    assign inv_color   = st_q.inv_color;
    assign inv_blank   = st_q.inv_blank;
    assign vpos        = st_q.vpos;
    assign hpos        = st_q.hpos;
    assign scrbg_color = st_q.bgc;
endmodule

// File: rtl/osd_wr_engine.sv
module osd_wr_engine
    import osd_cmd_pkg::*;
#(
    parameter int ROWS = 12,
    parameter int COLS = 28,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_act,
    input  logic             set_addr,
    input  logic [ROW_W-1:0] addr_row,
    input  logic [COL_W-1:0] addr_col,
    input  logic             addr_fill,
    input  logic             chr_go,
    input  logic             line_go,
    input  logic [REC_W-1:0] rec_in,
    output logic             mem_we,
    output logic             mem_line,
    output logic [ROW_W-1:0] mem_row,
    output logic [COL_W-1:0] mem_col,
    output logic [REC_W-1:0] mem_data,
    output logic             busy
);
    typedef struct packed {
        wr_mode_e         mode;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             fill;
        logic [REC_W-1:0] rec;
    } eng_st_t;

    eng_st_t st_d, st_q;
    logic    at_last;

    assign at_last = (st_q.row == ROW_W'(ROWS - 1)) && (st_q.col == COL_W'(COLS - 1));

    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;
        if (st_q.mode == WR_IDLE) begin
            if (set_addr) begin
                st_d.row  = addr_row;
                st_d.col  = addr_col;
                st_d.fill = addr_fill;
            end
            if (chr_go) begin
                st_d.mode = WR_CHR;
                st_d.rec  = rec_in;
            end else if (line_go) begin
                st_d.mode = WR_LINE;
                st_d.rec  = rec_in;
            end
        end else if (!hsync_act) begin
            mem_we = 1'b1;
            if (st_q.mode == WR_LINE) begin
                st_d.mode = WR_IDLE;
            end else begin
                if (st_q.col >= COL_W'(COLS - 1)) begin
                    st_d.col = '0;
                    st_d.row = (st_q.row >= ROW_W'(ROWS - 1)) ? '0 : st_q.row + 1'b1;
                end else begin
                    st_d.col = st_q.col + 1'b1;
                end
                if (!st_q.fill || at_last) st_d.mode = WR_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: WR_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign mem_line = (st_q.mode == WR_LINE);
    assign mem_row  = st_q.row;
    assign mem_col  = st_q.col;
    assign mem_data = st_q.rec;
    assign busy     = (st_q.mode != WR_IDLE);
endmodule

// File: rtl/osd_cmd_rx.sv
module osd_cmd_rx
    import osd_cmd_pkg::*;
#(
    parameter int ROWS = 12,
    parameter int COLS = 28,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_cs_n,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               msb_first,
    input  logic               hsync_act,
    output logic               mem_we,
    output logic               mem_line,
    output logic [ROW_W-1:0]   mem_row,
    output logic [COL_W-1:0]   mem_col,
    output logic [REC_W-1:0]   mem_data,
    output logic               busy,
    output logic               en_sprite,
    output logic               en_scrbg,
    output logic               en_disp,
    output logic               inv_color,
    output logic               inv_blank,
    output logic [POS_W-1:0]   vpos,
    output logic [POS_W-1:0]   hpos,
    output logic [COLOR_W-1:0] scrbg_color
);
    logic             word_vld;
    logic [CMD_W-1:0] word;
    logic             set_addr, addr_fill, chr_go, line_go;
    logic [ROW_W-1:0] addr_row;
    logic [COL_W-1:0] addr_col;
    logic [REC_W-1:0] rec;

    osd_ser_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (ser_cs_n),
        .sclk      (ser_clk),
        .sdat      (ser_dat),
        .msb_first (msb_first),
        .word_vld  (word_vld),
        .word      (word)
    );

    osd_cmd_decode #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_vld    (word_vld),
        .word        (word),
        .busy        (busy),
        .set_addr    (set_addr),
        .addr_row    (addr_row),
        .addr_col    (addr_col),
        .addr_fill   (addr_fill),
        .chr_go      (chr_go),
        .line_go     (line_go),
        .rec         (rec),
        .en_sprite   (en_sprite),
        .en_scrbg    (en_scrbg),
        .en_disp     (en_disp),
        .inv_color   (inv_color),
        .inv_blank   (inv_blank),
        .vpos        (vpos),
        .hpos        (hpos),
        .scrbg_color (scrbg_color)
    );

    osd_wr_engine #(.ROWS(ROWS), .COLS(COLS)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync_act (hsync_act),
        .set_addr  (set_addr),
        .addr_row  (addr_row),
        .addr_col  (addr_col),
        .addr_fill (addr_fill),
        .chr_go    (chr_go),
        .line_go   (line_go),
        .rec_in    (rec),
        .mem_we    (mem_we),
        .mem_line  (mem_line),
        .mem_row   (mem_row),
        .mem_col   (mem_col),
        .mem_data  (mem_data),
        .busy      (busy)
    );
endmodule

// File: rtl/osd_cmd_chk.sv
module osd_cmd_chk #(
    parameter int ROWS = 12,
    parameter int COLS = 28,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hsync_act,
    input logic             mem_we,
    input logic             mem_line,
    input logic [ROW_W-1:0] mem_row,
    input logic [COL_W-1:0] mem_col,
    input logic             busy
);
    assert_no_write_in_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_act |-> !mem_we);

    assert_write_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    assert_col_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_line && mem_col < COL_W'(COLS - 1)) |=>
            (mem_col == $past(mem_col) + 1'b1) && $stable(mem_row));

    assert_wrap_to_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_line && mem_row == ROW_W'(ROWS - 1) && mem_col == COL_W'(COLS - 1)) |=>
            (mem_row == '0 && mem_col == '0));

    assert_line_keeps_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_line) |=> ($stable(mem_row) && $stable(mem_col) && !busy));

    assert_line_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_line) |=> !mem_we);
endmodule

bind osd_cmd_rx osd_cmd_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync_act (hsync_act),
    .mem_we    (mem_we),
    .mem_line  (mem_line),
    .mem_row   (mem_row),
    .mem_col   (mem_col),
    .busy      (busy)
);

// File: tb/test_osd_cmd_rx.sv
module test_osd_cmd_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_cs_n = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0, msb_first = 1'b1, hsync_act = 1'b0;
    logic mem_we, mem_line, busy, en_sprite, en_scrbg, en_disp, inv_color, inv_blank;
    logic [3:0] mem_row, scrbg_color;
    logic [4:0] mem_col;
    logic [23:0] mem_data;
    logic [8:0] vpos, hpos;

    always #4 clk = ~clk;

    osd_cmd_rx i_osd_cmd_rx (
        .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .msb_first(msb_first), .hsync_act(hsync_act), .mem_we(mem_we), .mem_line(mem_line),
        .mem_row(mem_row), .mem_col(mem_col), .mem_data(mem_data), .busy(busy),
        .en_sprite(en_sprite), .en_scrbg(en_scrbg), .en_disp(en_disp), .inv_color(inv_color),
        .inv_blank(inv_blank), .vpos(vpos), .hpos(hpos), .scrbg_color(scrbg_color)
    );

    int n_cmp = 0, n_bad = 0;
    logic done = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit   m_bits[$];
    bit   m_psclk, m_wvld;
    int   m_word, m_mode, m_row, m_col, m_fill, m_rec, m_stc, m_stl;
    int   m_en, m_pol, m_vpos, m_hpos, m_bgc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bits.delete(); m_psclk = 0; m_wvld = 0; m_word = 0; m_mode = 0; m_row = 0;
            m_col = 0; m_fill = 0; m_rec = 0; m_stc = 0; m_stl = 0; m_en = 0; m_pol = 0;
            m_vpos = 0; m_hpos = 0; m_bgc = 0;
        end else begin
            if (m_mode != 0) begin
                if (!hsync_act) begin
                    if (m_mode == 2) m_mode = 0;
                    else begin
                        automatic bit last = (m_row == 11 && m_col == 27);
                        if (m_col >= 27) begin m_col = 0; m_row = (m_row >= 11) ? 0 : m_row + 1; end
                        else m_col++;
                        if (!m_fill || last) m_mode = 0;
                    end
                end
            end else if (m_wvld) begin
                automatic int g = (m_word >> 12) & 15;
                automatic int p = m_word & 'hFFF;
                case (g)
                    0: begin m_row = (m_word >> 8) & 15; m_col = m_word & 31; m_fill = (m_word >> 7) & 1; end
                    1: m_stc = p;
                    2: begin m_rec = (m_stc << 12) | p; m_mode = 1; end
                    3: m_stl = p;
                    4: begin m_rec = (m_stl << 12) | p; m_mode = 2; end
                    5: begin
                        if (((m_word >> 8) & 15) == 0) m_en = ((m_word >> 7) & 1) * 4 + ((m_word >> 6) & 1) * 2 + ((m_word >> 4) & 1);
                        else if (((m_word >> 9) & 7) == 6) m_vpos = m_word & 'h1FF;
                        else if (((m_word >> 9) & 7) == 7) m_hpos = m_word & 'h1FF;
                    end
                    7: if (((m_word >> 4) & 'hFF) == 'hC0) m_bgc = m_word & 15;
                    13: if (((m_word >> 10) & 3) == 0) m_pol = m_word & 3;
                    default: ;
                endcase
            end
            m_wvld = 0;
            if (ser_cs_n) m_bits.delete();
            else if (ser_clk && !m_psclk) begin
                m_bits.push_back(ser_dat);
                if (m_bits.size() == 16) begin
                    m_word = 0;
                    for (int i = 0; i < 16; i++)
                        if (m_bits[i]) m_word |= msb_first ? (1 << (15 - i)) : (1 << i);
                    m_wvld = 1;
                    m_bits.delete();
                end
            end
            m_psclk = ser_clk;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic bit exp_we = (m_mode != 0) && !hsync_act;
            check(hsync_act ? "R9 mem_we" : "R6 mem_we", mem_we, exp_we);
            check("R6 mem_row", mem_row, m_row);
            check("R6 mem_col", mem_col, m_col);
            check("R6 mem_data", mem_data, m_rec);
            check("R8 mem_line", mem_line, m_mode == 2);
            check("R10 busy", busy, m_mode != 0);
            check("R4 enables", {en_sprite, en_scrbg, en_disp}, m_en);
            check("R4 polarity", {inv_blank, inv_color}, m_pol);
            check("R4 vpos", vpos, m_vpos);
            check("R4 hpos", hpos, m_hpos);
            check("R4 scrbg_color", scrbg_color, m_bgc);
        end
    end

    // shadow memory built from the write port
    logic [23:0] chr_mem [12][28];
    logic [23:0] line_mem [12];
    int wr_cnt = 0;
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (mem_line) line_mem[mem_row] = mem_data;
            else chr_mem[mem_row][mem_col] = mem_data;
            wr_cnt++;
        end
    end

    task automatic bit_out(input bit b);
        @(negedge clk) begin ser_dat = b; ser_clk = 1'b0; end
        @(negedge clk);
        @(negedge clk) ser_clk = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w, input int nbits = 16);
        @(negedge clk) ser_cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) bit_out(msb_first ? w[15 - i] : w[i]);
        @(negedge clk) begin ser_clk = 1'b0; ser_cs_n = 1'b1; end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
                done = 1'b1;
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset outs", {en_sprite, en_scrbg, en_disp, inv_color, inv_blank, busy, mem_we}, 0);
        check("R1 reset addr", {mem_row, mem_col}, 0);
        check("R1 reset regs", {vpos, hpos, scrbg_color}, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {en_sprite, en_scrbg, en_disp, busy}, 0);

        // R2/R4 MSB-first register words
        msb_first = 1'b1;
        send(16'h50D0);
        check("R4 enables set", {en_sprite, en_scrbg, en_disp}, 3'b111);
        send(16'h5CAB);
        check("R2 msb vpos", vpos, 9'h0AB);
        send(16'h7C05);
        check("R4 scrbg", scrbg_color, 4'h5);
        send(16'hD003);
        check("R4 polarity", {inv_blank, inv_color}, 2'b11);
        // R2 LSB-first
        msb_first = 1'b0;
        send(16'h5F23);
        check("R2 lsb hpos", hpos, 9'h123);
        msb_first = 1'b1;

        // R3 partial word discarded
        send(16'h5F55, 7);
        check("R3 partial ignored", hpos, 9'h123);
        send(16'h5C11);
        check("R3 next word clean", vpos, 9'h011);

        // R5/R6 character write, held by sync (R9)
        send(16'h0205);
        check("R5 addr set", {mem_row, mem_col}, {4'd2, 5'd5});
        send(16'h1ABC);
        check("R6 stage no write", wr_cnt, 0);
        hsync_act = 1'b1;
        send(16'h2C7F);
        repeat (4) @(negedge clk);
        check("R9 held busy", busy, 1);
        check("R9 no write in sync", wr_cnt, 0);
        hsync_act = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 released write", wr_cnt, 1);
        check("R6 record", chr_mem[2][5], 24'hABCC7F);
        check("R6 col advanced", {mem_row, mem_col}, {4'd2, 5'd6});

        // R7 column and row wrap
        send(16'h001B);
        send(16'h2001);
        check("R7 row advance", {mem_row, mem_col}, {4'd1, 5'd0});
        send(16'h2002);
        check("R7 landed next row", chr_mem[1][0], 24'hABC002);
        send(16'h0B1B);
        send(16'h2004);
        check("R7 last cell", chr_mem[11][27], 24'hABC004);
        check("R7 wrap origin", {mem_row, mem_col}, 0);

        // R8 line write keeps address
        send(16'h0403);
        send(16'h3123);
        send(16'h4456);
        check("R8 line record", line_mem[4], 24'h123456);
        check("R8 addr kept", {mem_row, mem_col}, {4'd4, 5'd3});
        send(16'h2003);
        check("R8 char after line", chr_mem[4][3], 24'hABC003);

        // R10 fill run with a word arriving mid-run (R11)
        begin
            automatic int base = wr_cnt;
            send(16'h0580);
            send(16'h2055);
            check("R10 busy in fill", busy, 1);
            send(16'h5EAA);
            while (busy) @(negedge clk);
            @(negedge clk);
            check("R10 write count", wr_cnt - base, 196);
            check("R10 first cell", chr_mem[5][0], 24'hABC055);
            check("R10 last cell", chr_mem[11][27], 24'hABC055);
            check("R10 end addr", {mem_row, mem_col}, 0);
            check("R11 word ignored", hpos, 9'h123);
        end

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule